// File: doc/BRIEF.md
# Cascaded DMA Page Address Generator

This block sits beside a pair of four-channel DMA controllers that are chained into one eight-channel system. Channels 0 to 3 move bytes and channels 4 to 7 move 16-bit words. Channel 4 is the link that chains the byte controller into the word controller, so it never carries a transfer of its own. The block keeps one 8-bit page register per channel. When the active controller presents its channel number and its 16-bit current address, the block forms the 24-bit physical address and marks the cycle as a byte or a word access.

Word controllers count in words and hold a byte address that has been shifted right by one. For those channels the physical address is the upper seven page bits, then the controller address, then a zero. The controller address never carries into the page. This means a transfer has to stay inside one 64 KiB window (byte) or one 128 KiB window (word). A second path checks a requested transfer (channel, byte start address, byte length) against these limits. It returns either an error or the values software would load into the controller: page, controller start address and terminal count.

Top module: `dma_page_addr_gen`

## Requirements
- R1: After a synchronous reset, `phys_valid` and `req_done` are 0 and every page register reads as 0x00.
- R2: A page write stores `pg_wr_data` into one channel, decoded from `pg_wr_slot`: slot 0x7 to channel 0, 0x3 to channel 1, 0x1 to channel 2, 0x2 to channel 3, 0xF to channel 4, 0xB to channel 5, 0x9 to channel 6 and 0xA to channel 7. A write to any other slot changes no page register.
- R3: For `xfer_chan` 0 to 3, one cycle after `xfer_valid` the block drives `phys_valid`=1, `phys_is_word`=0 and `phys_addr` = {page[7:0], xfer_addr[15:0]}. Requests on consecutive cycles give results on consecutive cycles.
- R4: For `xfer_chan` 5 to 7, one cycle after `xfer_valid` the block drives `phys_valid`=1, `phys_is_word`=1 and `phys_addr` = {page[7:1], xfer_addr[15:0], 1'b0}. Page bit 0 has no effect.
- R5: The page field of `phys_addr` equals the page register for every value of `xfer_addr`, including 0xFFFF (no carry into the page).
- R6: Channel 4 is the cascade link. An `xfer_valid` on channel 4 leaves `phys_valid` at 0, and a check request on channel 4 reports an error.
- R7: A byte-channel request passes when 1 ≤ length ≤ 65536 and the first and last bytes share address bits [23:16]. It then reports `prog_page` = start[23:16], `prog_addr` = start[15:0] and `prog_cnt` = length−1 (low 16 bits).
- R8: A word-channel request passes when the length is nonzero, even and ≤ 131072, the start is even, and the first and last bytes share address bits [23:17]. It then reports `prog_page` = start[23:16], `prog_addr` = start[16:1] and `prog_cnt` = length/2−1 (low 16 bits).
- R9: A request that fails any rule gives `req_err`=1 with `prog_page`, `prog_addr` and `prog_cnt` all 0. A window that runs past address 0xFFFFFF counts as a crossing.
- R10: `req_done` is 1 exactly one cycle after each `req_valid`.
- R11: A page write and an `xfer_valid` for the same channel in the same cycle give an address formed from the old page value. The new value applies from the next request onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_wr_en | input | 1 | Page register write strobe |
| pg_wr_slot | input | 4 | Page register slot offset |
| pg_wr_data | input | 8 | Page value to write |
| xfer_valid | input | 1 | Controller presents an active cycle |
| xfer_chan | input | 3 | Active channel number |
| xfer_addr | input | 16 | Controller current address |
| phys_valid | output | 1 | Physical address issued |
| phys_addr | output | 24 | Physical byte address |
| phys_is_word | output | 1 | 1 for a 16-bit access, 0 for a byte access |
| req_valid | input | 1 | Transfer check request |
| req_chan | input | 3 | Channel of the request |
| req_start | input | 24 | Physical byte start address |
| req_len | input | 18 | Length in bytes |
| req_done | output | 1 | Check result valid |
| req_err | output | 1 | Request breaks a limit |
| prog_page | output | 8 | Page value to load |
| prog_addr | output | 16 | Controller start address to load |
| prog_cnt | output | 16 | Terminal count to load (units − 1) |

## Verification
If a page register was decoded to the wrong channel, or picked up a write to an unmapped slot, the wrong page byte shows up in `phys_addr` one cycle after the next request on that channel. The bench therefore reads every channel back after each group of writes. A wrong choice of byte or word class shows the next cycle as a misplaced address or a wrong `phys_is_word`. The limit path is checked right at each rule's edge: maximum length, one byte over, a window that crosses, and one that just fits. A wrong comparison there flips `req_err` in the cycle after the request.

// File: rtl/dma_pg_pkg.sv
package dma_pg_pkg;

  // Slot offset of each channel's page register; a decoder outside this
  // block places the registers at these offsets, so the order is fixed.
  function automatic logic [3:0] chan_slot(input int ch);
    case (ch)
      0:       chan_slot = 4'h7;
      1:       chan_slot = 4'h3;
      2:       chan_slot = 4'h1;
      3:       chan_slot = 4'h2;
      4:       chan_slot = 4'hF;
      5:       chan_slot = 4'hB;
      6:       chan_slot = 4'h9;
      7:       chan_slot = 4'hA;
      default: chan_slot = 4'h0;
    endcase
  endfunction

endpackage

// File: rtl/dma_pg_regfile.sv
module dma_pg_regfile
  import dma_pg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int PAGE_W = 8,
  parameter int SLOT_W = 4,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [PAGE_W-1:0] wr_data,
  input  logic [CH_W-1:0]   rd_chan,
  output logic [PAGE_W-1:0] rd_page
);

  logic [PAGE_W-1:0] page_bank [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_page
    localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(chan_slot(g));
    logic [PAGE_W-1:0] page_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        page_q <= '0;
      end else if (wr_en && (wr_slot == MY_SLOT)) begin
        page_q <= wr_data;
      end
    end

    assign page_bank[g] = page_q;
  end

  assign rd_page = page_bank[rd_chan];

endmodule

// File: rtl/dma_pg_addr_path.sv
module dma_pg_addr_path #(
  parameter int NUM_CH     = 8,
  parameter int PAGE_W     = 8,
  parameter int ADDR_W     = 16,
  parameter int CASCADE_CH = 4,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int PHYS_W = PAGE_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [PAGE_W-1:0] in_page,
  output logic              out_valid,
  output logic [PHYS_W-1:0] out_addr,
  output logic              out_word
);

  localparam logic [CH_W-1:0] FIRST_WORD_CH = CH_W'(NUM_CH / 2);
  localparam logic [CH_W-1:0] LINK_CH       = CH_W'(CASCADE_CH);

  logic              is_word;
  logic              issue;
  logic [PHYS_W-1:0] byte_form;
  logic [PHYS_W-1:0] word_form;

  assign is_word   = (in_chan >= FIRST_WORD_CH);
  assign issue     = in_valid && (in_chan != LINK_CH);
  // The controller address is used as-is; its carry never reaches the page.
  assign byte_form = {in_page, in_addr};
  assign word_form = {in_page[PAGE_W-1:1], in_addr, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_word  <= 1'b0;
    end else begin
      out_valid <= issue;
      if (issue) begin
        out_addr <= is_word ? word_form : byte_form;
        out_word <= is_word;
      end
    end
  end

endmodule

// File: rtl/dma_pg_req_check.sv
module dma_pg_req_check #(
  parameter int NUM_CH     = 8,
  parameter int PAGE_W     = 8,
  parameter int ADDR_W     = 16,
  parameter int CASCADE_CH = 4,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int PHYS_W = PAGE_W + ADDR_W,
  localparam int LEN_W  = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [PHYS_W-1:0] in_start,
  input  logic [LEN_W-1:0]  in_len,
  output logic              out_done,
  output logic              out_err,
  output logic [PAGE_W-1:0] out_page,
  output logic [ADDR_W-1:0] out_addr,
  output logic [ADDR_W-1:0] out_cnt
);

  localparam logic [CH_W-1:0]   FIRST_WORD_CH = CH_W'(NUM_CH / 2);
  localparam logic [CH_W-1:0]   LINK_CH       = CH_W'(CASCADE_CH);
  localparam logic [LEN_W-1:0]  BYTE_MAX      = LEN_W'(1) << ADDR_W;
  localparam logic [LEN_W-1:0]  WORD_MAX      = LEN_W'(1) << (ADDR_W + 1);
  localparam logic [PHYS_W:0]   ONE_P         = (PHYS_W + 1)'(1);
  localparam logic [ADDR_W-1:0] ONE_A         = ADDR_W'(1);

  logic              is_word;
  logic [PHYS_W:0]   last_byte;
  logic              cross_b;
  logic              cross_w;
  logic              bad_b;
  logic              bad_w;
  logic              bad;
  logic [ADDR_W-1:0] addr_sel;
  logic [ADDR_W-1:0] cnt_sel;

  assign is_word   = (in_chan >= FIRST_WORD_CH);
  // One extra bit so that a window running past the top is seen as a crossing.
  assign last_byte = {1'b0, in_start} + (PHYS_W + 1)'(in_len) - ONE_P;
  assign cross_b   = {1'b0, in_start[PHYS_W-1:ADDR_W]}   != last_byte[PHYS_W:ADDR_W];
  assign cross_w   = {1'b0, in_start[PHYS_W-1:ADDR_W+1]} != last_byte[PHYS_W:ADDR_W+1];

  assign bad_b = (in_len > BYTE_MAX) || cross_b;
  assign bad_w = in_len[0] || in_start[0] || (in_len > WORD_MAX) || cross_w;
  assign bad   = (in_len == '0) || (in_chan == LINK_CH) || (is_word ? bad_w : bad_b);

  assign addr_sel = is_word ? in_start[ADDR_W:1] : in_start[ADDR_W-1:0];
  assign cnt_sel  = is_word ? (in_len[ADDR_W:1] - ONE_A) : (in_len[ADDR_W-1:0] - ONE_A);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_done <= 1'b0;
      out_err  <= 1'b0;
      out_page <= '0;
      out_addr <= '0;
      out_cnt  <= '0;
    end else begin
      out_done <= in_valid;
      if (in_valid) begin
        out_err <= bad;
        if (bad) begin
          out_page <= '0;
          out_addr <= '0;
          out_cnt  <= '0;
        end else begin
          out_page <= in_start[PHYS_W-1:ADDR_W];
          out_addr <= addr_sel;
          out_cnt  <= cnt_sel;
        end
      end
    end
  end

endmodule

// File: rtl/dma_page_addr_gen.sv
module dma_page_addr_gen #(
  parameter int NUM_CH     = 8,
  parameter int PAGE_W     = 8,
  parameter int ADDR_W     = 16,
  parameter int SLOT_W     = 4,
  parameter int CASCADE_CH = 4,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int PHYS_W = PAGE_W + ADDR_W,
  localparam int LEN_W  = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pg_wr_en,
  input  logic [SLOT_W-1:0] pg_wr_slot,
  input  logic [PAGE_W-1:0] pg_wr_data,
  input  logic              xfer_valid,
  input  logic [CH_W-1:0]   xfer_chan,
  input  logic [ADDR_W-1:0] xfer_addr,
  output logic              phys_valid,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              phys_is_word,
  input  logic              req_valid,
  input  logic [CH_W-1:0]   req_chan,
  input  logic [PHYS_W-1:0] req_start,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_done,
  output logic              req_err,
  output logic [PAGE_W-1:0] prog_page,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [ADDR_W-1:0] prog_cnt
);

  logic [PAGE_W-1:0] cur_page;

  dma_pg_regfile #(
    .NUM_CH (NUM_CH),
    .PAGE_W (PAGE_W),
    .SLOT_W (SLOT_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (pg_wr_en),
    .wr_slot (pg_wr_slot),
    .wr_data (pg_wr_data),
    .rd_chan (xfer_chan),
    .rd_page (cur_page)
  );

  dma_pg_addr_path #(
    .NUM_CH     (NUM_CH),
    .PAGE_W     (PAGE_W),
    .ADDR_W     (ADDR_W),
    .CASCADE_CH (CASCADE_CH)
  ) u_addr (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (xfer_valid),
    .in_chan   (xfer_chan),
    .in_addr   (xfer_addr),
    .in_page   (cur_page),
    .out_valid (phys_valid),
    .out_addr  (phys_addr),
    .out_word  (phys_is_word)
  );

  dma_pg_req_check #(
    .NUM_CH     (NUM_CH),
    .PAGE_W     (PAGE_W),
    .ADDR_W     (ADDR_W),
    .CASCADE_CH (CASCADE_CH)
  ) u_check (
    .clk      (clk),
    .rst      (rst),
    .in_valid (req_valid),
    .in_chan  (req_chan),
    .in_start (req_start),
    .in_len   (req_len),
    .out_done (req_done),
    .out_err  (req_err),
    .out_page (prog_page),
    .out_addr (prog_addr),
    .out_cnt  (prog_cnt)
  );

endmodule

// File: rtl/dma_pg_chk.sv
module dma_pg_chk #(
  parameter int NUM_CH     = 8,
  parameter int PAGE_W     = 8,
  parameter int ADDR_W     = 16,
  parameter int CASCADE_CH = 4,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int PHYS_W = PAGE_W + ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_valid,
  input logic [CH_W-1:0]   xfer_chan,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic              phys_valid,
  input logic [PHYS_W-1:0] phys_addr,
  input logic              phys_is_word,
  input logic              req_valid,
  input logic              req_done,
  input logic              req_err,
  input logic [PAGE_W-1:0] prog_page,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [ADDR_W-1:0] prog_cnt
);

  localparam logic [CH_W-1:0] LINK_CH = CH_W'(CASCADE_CH);

  // R3
  byte_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (phys_valid && !phys_is_word) |-> (phys_addr[ADDR_W-1:0] == $past(xfer_addr)));

  // R4
  word_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (phys_valid && phys_is_word) |->
      (!phys_addr[0] && (phys_addr[ADDR_W:1] == $past(xfer_addr))));

  // R6
  cascade_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && (xfer_chan == LINK_CH)) |=> !phys_valid);

  // R9
  err_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (req_done && req_err) |-> ((prog_page == '0) && (prog_addr == '0) && (prog_cnt == '0)));

  // R10
  done_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> req_done);

  // R10
  done_only_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !req_done);

endmodule

bind dma_page_addr_gen dma_pg_chk #(
  .NUM_CH     (NUM_CH),
  .PAGE_W     (PAGE_W),
  .ADDR_W     (ADDR_W),
  .CASCADE_CH (CASCADE_CH)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .xfer_valid   (xfer_valid),
  .xfer_chan    (xfer_chan),
  .xfer_addr    (xfer_addr),
  .phys_valid   (phys_valid),
  .phys_addr    (phys_addr),
  .phys_is_word (phys_is_word),
  .req_valid    (req_valid),
  .req_done     (req_done),
  .req_err      (req_err),
  .prog_page    (prog_page),
  .prog_addr    (prog_addr),
  .prog_cnt     (prog_cnt)
);

// File: tb/sim_dma_page_addr_gen.sv
module sim_dma_page_addr_gen;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pg_wr_en = 1'b0;
  logic [3:0]  pg_wr_slot = '0;
  logic [7:0]  pg_wr_data = '0;
  logic        xfer_valid = 1'b0;
  logic [2:0]  xfer_chan = '0;
  logic [15:0] xfer_addr = '0;
  logic        phys_valid;
  logic [23:0] phys_addr;
  logic        phys_is_word;
  logic        req_valid = 1'b0;
  logic [2:0]  req_chan = '0;
  logic [23:0] req_start = '0;
  logic [17:0] req_len = '0;
  logic        req_done;
  logic        req_err;
  logic [7:0]  prog_page;
  logic [15:0] prog_addr;
  logic [15:0] prog_cnt;

  int tests = 0;
  int fails = 0;

  logic [7:0]  pg_model [8];
  logic [24:0] addr_q [$];
  string       addr_tag_q [$];
  logic [40:0] req_q [$];
  string       req_tag_q [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_page_addr_gen u0 (
    .clk (clk), .rst (rst),
    .pg_wr_en (pg_wr_en), .pg_wr_slot (pg_wr_slot), .pg_wr_data (pg_wr_data),
    .xfer_valid (xfer_valid), .xfer_chan (xfer_chan), .xfer_addr (xfer_addr),
    .phys_valid (phys_valid), .phys_addr (phys_addr), .phys_is_word (phys_is_word),
    .req_valid (req_valid), .req_chan (req_chan), .req_start (req_start), .req_len (req_len),
    .req_done (req_done), .req_err (req_err),
    .prog_page (prog_page), .prog_addr (prog_addr), .prog_cnt (prog_cnt)
  );

  function automatic int slot_to_ch(input logic [3:0] s);
    case (s)
      4'h7: return 0;
      4'h3: return 1;
      4'h1: return 2;
      4'h2: return 3;
      4'hF: return 4;
      4'hB: return 5;
      4'h9: return 6;
      4'hA: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic logic [24:0] exp_phys(input int ch, input logic [15:0] a);
    logic [7:0] p;
    p = pg_model[ch];
    if (ch >= 4) return {1'b1, p[7:1], a, 1'b0};
    return {1'b0, p, a};
  endfunction

  function automatic logic [40:0] exp_req(input int ch, input logic [23:0] st, input logic [17:0] len);
    logic [24:0] last;
    logic        bad;
    logic [15:0] a;
    logic [15:0] c;
    last = {1'b0, st} + {7'd0, len} - 25'd1;
    if (ch >= 4) begin
      bad = (len == 0) || len[0] || st[0] || (len > 18'd131072) || ({1'b0, st[23:17]} != last[24:17]);
      a   = st[16:1];
      c   = 16'((len >> 1) - 18'd1);
    end else begin
      bad = (len == 0) || (len > 18'd65536) || ({1'b0, st[23:16]} != last[24:16]);
      a   = st[15:0];
      c   = 16'(len - 18'd1);
    end
    if (ch == 4) bad = 1'b1;
    if (bad) return {1'b1, 40'd0};
    return {1'b0, st[23:16], a, c};
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp, input string what);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // Monitor: pops expectations as results appear.
  always @(negedge clk) begin
    if (!rst) begin
      if (phys_valid) begin
        if (addr_q.size() == 0) begin
          check("R6", 64'(phys_valid), 64'd0, "unexpected address issued");
        end else begin
          check(addr_tag_q.pop_front(), 64'({phys_is_word, phys_addr}), 64'(addr_q.pop_front()), "phys");
        end
      end
      if (req_done) begin
        if (req_q.size() == 0) begin
          check("R10", 64'(req_done), 64'd0, "unexpected done");
        end else begin
          check(req_tag_q.pop_front(), 64'({req_err, prog_page, prog_addr, prog_cnt}),
                64'(req_q.pop_front()), "req");
        end
      end
    end
  end

  task automatic wr_page(input logic [3:0] s, input logic [7:0] d);
    int ch;
    @(negedge clk);
    pg_wr_en = 1'b1; pg_wr_slot = s; pg_wr_data = d;
    @(negedge clk);
    pg_wr_en = 1'b0;
    ch = slot_to_ch(s);
    if (ch >= 0) pg_model[ch] = d;
  endtask

  task automatic xfer(input int ch, input logic [15:0] a, input string tag);
    @(negedge clk);
    xfer_valid = 1'b1; xfer_chan = 3'(ch); xfer_addr = a;
    if (ch != 4) begin
      addr_q.push_back(exp_phys(ch, a));
      addr_tag_q.push_back(tag);
    end
    @(negedge clk);
    xfer_valid = 1'b0;
    if (ch == 4) check(tag, 64'(phys_valid), 64'd0, "cascade channel issued address");
  endtask

  task automatic request(input int ch, input logic [23:0] st, input logic [17:0] len, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_chan = 3'(ch); req_start = st; req_len = len;
    req_q.push_back(exp_req(ch, st, len));
    req_tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic read_all(input string tag);
    for (int c = 0; c < 8; c++) begin
      if (c != 4) xfer(c, 16'hA5C3 + 16'(c), tag);
    end
  endtask

  initial begin
    for (int c = 0; c < 8; c++) pg_model[c] = 8'h00;
    repeat (3) @(negedge clk);
    check("R1", 64'(phys_valid), 64'd0, "phys_valid in reset");
    check("R1", 64'(req_done), 64'd0, "req_done in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1", 64'({phys_valid, req_done}), 64'd0, "outputs after reset");
    read_all("R1");

    // R2: program every channel through its slot
    wr_page(4'h7, 8'h10); wr_page(4'h3, 8'h21); wr_page(4'h1, 8'h32); wr_page(4'h2, 8'h43);
    wr_page(4'hF, 8'h54); wr_page(4'hB, 8'h65); wr_page(4'h9, 8'h77); wr_page(4'hA, 8'h88);
    read_all("R2");
    // R2: unmapped slots change nothing
    wr_page(4'h0, 8'hEE); wr_page(4'h4, 8'hDD); wr_page(4'hC, 8'hCC); wr_page(4'h8, 8'hBB);
    read_all("R2");

    // R3 byte forms, R4 word forms with odd page (bit 0 ignored)
    xfer(0, 16'h0000, "R3");
    xfer(3, 16'h8001, "R3");
    xfer(6, 16'h1234, "R4");
    xfer(7, 16'h0001, "R4");
    // R5 top of address, no carry into page
    xfer(1, 16'hFFFF, "R5");
    xfer(5, 16'hFFFF, "R5");
    // R6 cascade channel
    xfer(4, 16'h4444, "R6");

    // R3 back-to-back requests
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      xfer_valid = 1'b1; xfer_chan = 3'(k); xfer_addr = 16'h0100 * 16'(k + 1);
      addr_q.push_back(exp_phys(k, 16'h0100 * 16'(k + 1)));
      addr_tag_q.push_back("R3");
    end
    @(negedge clk);
    xfer_valid = 1'b0;

    // R11 write and use in the same cycle
    @(negedge clk);
    pg_wr_en = 1'b1; pg_wr_slot = 4'h3; pg_wr_data = 8'h99;
    xfer_valid = 1'b1; xfer_chan = 3'd1; xfer_addr = 16'h0042;
    addr_q.push_back(exp_phys(1, 16'h0042));
    addr_tag_q.push_back("R11");
    @(negedge clk);
    pg_wr_en = 1'b0; xfer_valid = 1'b0;
    pg_model[1] = 8'h99;
    xfer(1, 16'h0042, "R11");

    // R7 byte checks
    request(1, 24'h123400, 18'h00100, "R7");
    request(0, 24'h050000, 18'd65536, "R7");
    request(2, 24'h05FFFF, 18'd1, "R7");
    // R8 word checks
    request(5, 24'h240100, 18'h00200, "R8");
    request(6, 24'h060000, 18'd131072, "R8");
    request(7, 24'h0EFFF0, 18'h00020, "R8");
    // R9 failures
    request(0, 24'h050000, 18'd65537, "R9");
    request(3, 24'h05FFF0, 18'h00020, "R9");
    request(1, 24'h001000, 18'd0, "R9");
    request(2, 24'hFFFFF0, 18'h00020, "R9");
    request(5, 24'h000100, 18'h00101, "R9");
    request(6, 24'h000101, 18'h00100, "R9");
    request(7, 24'h000000, 18'd131074, "R9");
    request(5, 24'h07FFF0, 18'h00020, "R9");
    request(4, 24'h000000, 18'h00010, "R6");

    // R10 back-to-back requests
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      req_valid = 1'b1; req_chan = 3'(k); req_start = 24'h300000 + 24'(k * 16); req_len = 18'd8;
      req_q.push_back(exp_req(k, 24'h300000 + 24'(k * 16), 18'd8));
      req_tag_q.push_back("R10");
    end
    @(negedge clk);
    req_valid = 1'b0;

    repeat (3) @(negedge clk);
    check("R10", 64'(req_q.size()), 64'd0, "pending check results");
    check("R3", 64'(addr_q.size()), 64'd0, "pending addresses");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule